// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block steps a processor subsystem between its operating and low-power states. Software writes a 2-bit mode code, a timer-expiry select bit and a high/low divide choice, then pulses a request strobe. The block then moves to one of these states: normal, doze, sleep, deep-sleep or power-down. From its state it drives the general clock enable, the PLL enable, the core domain enable, the peripheral domain enable, and the power-of-two exponent by which the general clock divides the PLL output.

Wake-up events arrive on a six-bit source vector and pass through a per-source enable mask. Each low-power state has its own exit path. Doze and normal-low return to normal-high through a short fixed resynchronisation window. Sleep returns the same way. Deep-sleep first waits out a programmable oscillator settling count. Power-down leaves only when a timer wake is followed by a hard reset, and it then waits for a supply settling count before the oscillator count. A hard reset otherwise forces normal-high at once.

Top module: `lpm_sequencer`

## Requirements
- R1: While `rstN` is low, and one cycle after a `hardRst` pulse in any state other than 6, 8 or 9, `pmState` is 0 (normal-high) and `gclkEn`, `pllEn`, `coreEn` and `periphEn` are all 1.
- R2: A `modeReq` pulse taken in state 0 or 1 selects a new state from `modeSel`. Code 00 gives normal: state 1 if `useLow` is 1, otherwise state 0. Code 01 gives doze: state 3 if `useLow` is 1, otherwise state 2. Code 10 gives sleep (state 4). Code 11 gives deep-sleep (state 5) when `timerExpSel` is 1 and power-down (state 6) when it is 0. A request that names the current state changes nothing.
- R3: `divExp` equals `divHigh` in every state except 1 and 3. In states 1 and 3 it equals `divLow` + 1.
- R4: In doze (states 2 and 3), `coreEn` is 0 while `gclkEn`, `pllEn` and `periphEn` are 1. `coreEn` is never 1 unless both clock enables are 1.
- R5: In sleep, `pllEn` is 1 and `gclkEn`, `coreEn` and `periphEn` are 0. In deep-sleep and power-down all four enables are 0.
- R6: Doze exits on any enabled wake or on a `modeReq` with code 00. Normal-low exits on any enabled wake or on a request for state 0. Either exit holds state 7 (return) for exactly 3 cycles with `coreEn` 0, then enters state 0.
- R7: Sleep exits to state 7 on an enabled wake from sources 1 to 5. The wake bits are: 0 internal interrupt, 1 external interrupt, 2 real-time clock, 3 periodic timer, 4 decrementer, 5 timebase. Source 0 does not wake sleep.
- R8: Deep-sleep exits on the same sources as sleep. It goes to state 8 (oscillator settle) for `oscSettle`+1 cycles, with `pllEn` 1 and `gclkEn` 0, and then to state 0.
- R9: Power-down ignores wakes and a `hardRst` until an enabled timer wake (sources 2 to 5) has been seen there. A `hardRst` after such a wake gives state 9 (supply settle, all enables 0) for `supplySettle`+1 cycles, then state 8 for `oscSettle`+1 cycles, then state 0.
- R10: A source whose `wakeEn` bit is 0 causes no exit from any state.
- R11: `modeReq` has no effect in states 4 to 9. In doze, only code 00 acts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low power-on reset |
| modeReq | input | 1 | One-cycle mode request strobe |
| modeSel | input | 2 | Requested mode code |
| timerExpSel | input | 1 | Chooses deep-sleep (1) or power-down (0) for code 11 |
| useLow | input | 1 | Chooses the low divide variant of normal or doze |
| divHigh | input | DIV_W | High divide exponent field |
| divLow | input | DIV_W | Low divide field (exponent minus one) |
| oscSettle | input | CNT_W | Oscillator settle count |
| supplySettle | input | CNT_W | Supply settle count |
| hardRst | input | 1 | Functional hard reset request |
| wakeSrc | input | 6 | Wake-up event vector |
| wakeEn | input | 6 | Per-source wake enable mask |
| pmState | output | 4 | Current power state code |
| divExp | output | DIV_W+1 | General clock divide exponent |
| gclkEn | output | 1 | General clock enable |
| pllEn | output | 1 | PLL enable |
| coreEn | output | 1 | Core domain enable |
| periphEn | output | 1 | Peripheral domain enable |

## Verification
The mode requests cover every code with both settings of `useLow` and `timerExpSel`, and repeat a request for the current state. This separates true transitions from no-ops and deep-sleep from power-down. The wake patterns use an internal-only source, a non-timer external source, a masked timer source and an enabled timer source. These show which state accepts which source, and that the mask is honoured. The cycle counts of states 7, 8 and 9 are sampled on every cycle of each window, so an off-by-one in any counter shows up. Hard reset is applied both before and after a timer wake in power-down.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  localparam int WAKE_BITS = 6;
  localparam logic [WAKE_BITS-1:0] SLEEP_WAKE_MASK = 6'b111110;
  localparam logic [WAKE_BITS-1:0] TIMER_WAKE_MASK = 6'b111100;
  localparam int RESYNC_CYCLES = 3;

  typedef enum logic [3:0] {
    PM_NORM_HI  = 4'd0,
    PM_NORM_LO  = 4'd1,
    PM_DOZE_HI  = 4'd2,
    PM_DOZE_LO  = 4'd3,
    PM_SLEEP    = 4'd4,
    PM_DEEP     = 4'd5,
    PM_PDOWN    = 4'd6,
    PM_RESYNC   = 4'd7,
    PM_OSC_WAIT = 4'd8,
    PM_SUP_WAIT = 4'd9
  } pmState_e;

  typedef struct packed {
    logic ldOsc;
    logic ldSup;
    logic ldResync;
    logic tmrClr;
    logic selLow;
  } pmStrobe_t;
endpackage

// File: rtl/lpm_datapath.sv
module lpm_datapath
  import lpm_pkg::*;
#(
  parameter int DIV_W = 3,
  parameter int CNT_W = 10
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  pmStrobe_t            strobe,
  input  logic [DIV_W-1:0]     divHigh,
  input  logic [DIV_W-1:0]     divLow,
  input  logic [CNT_W-1:0]     oscSettle,
  input  logic [CNT_W-1:0]     supplySettle,
  input  logic [WAKE_BITS-1:0] wakeSrc,
  input  logic [WAKE_BITS-1:0] wakeEn,
  output logic [WAKE_BITS-1:0] wakeHit,
  output logic [DIV_W:0]       divExp,
  output logic                 cntZero,
  output logic                 tmrSeen
);
  localparam logic [CNT_W-1:0] RESYNC_LOAD = CNT_W'(RESYNC_CYCLES - 1);

  logic [CNT_W-1:0] settleCnt;

  assign wakeHit = wakeSrc & wakeEn;
  assign cntZero = (settleCnt == '0);
  assign divExp  = strobe.selLow ? ({1'b0, divLow} + (DIV_W+1)'(1)) : {1'b0, divHigh};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                settleCnt <= '0;
    else if (strobe.ldOsc)    settleCnt <= oscSettle;
    else if (strobe.ldSup)    settleCnt <= supplySettle;
    else if (strobe.ldResync) settleCnt <= RESYNC_LOAD;
    else if (!cntZero)        settleCnt <= settleCnt - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                 tmrSeen <= 1'b0;
    else if (strobe.tmrClr)                    tmrSeen <= 1'b0;
    else if (|(wakeHit & TIMER_WAKE_MASK))     tmrSeen <= 1'b1;
  end
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 modeReq,
  input  logic [1:0]           modeSel,
  input  logic                 timerExpSel,
  input  logic                 useLow,
  input  logic                 hardRst,
  input  logic [WAKE_BITS-1:0] wakeHit,
  input  logic                 cntZero,
  input  logic                 tmrSeen,
  output pmState_e             curState,
  output pmStrobe_t            strobe,
  output logic                 gclkEn,
  output logic                 pllEn,
  output logic                 coreEn,
  output logic                 periphEn
);
  pmState_e nxtState;
  pmState_e reqTarget;
  logic     anyWake;
  logic     sleepWake;

  assign anyWake   = |wakeHit;
  assign sleepWake = |(wakeHit & SLEEP_WAKE_MASK);

  always_comb begin
    unique case (modeSel)
      2'b00:   reqTarget = useLow ? PM_NORM_LO : PM_NORM_HI;
      2'b01:   reqTarget = useLow ? PM_DOZE_LO : PM_DOZE_HI;
      2'b10:   reqTarget = PM_SLEEP;
      default: reqTarget = timerExpSel ? PM_DEEP : PM_PDOWN;
    endcase
  end

  always_comb begin
    nxtState        = curState;
    strobe          = '0;
    strobe.tmrClr   = (curState != PM_PDOWN);
    strobe.selLow   = (curState == PM_NORM_LO) || (curState == PM_DOZE_LO);
    unique case (curState)
      PM_NORM_HI: begin
        if (modeReq && reqTarget != curState) nxtState = reqTarget;
      end
      PM_NORM_LO: begin
        if (anyWake || (modeReq && reqTarget == PM_NORM_HI)) begin
          nxtState = PM_RESYNC; strobe.ldResync = 1'b1;
        end else if (modeReq && reqTarget != curState) begin
          nxtState = reqTarget;
        end
      end
      PM_DOZE_HI, PM_DOZE_LO: begin
        if (anyWake || (modeReq && modeSel == 2'b00)) begin
          nxtState = PM_RESYNC; strobe.ldResync = 1'b1;
        end
      end
      PM_SLEEP: begin
        if (sleepWake) begin
          nxtState = PM_RESYNC; strobe.ldResync = 1'b1;
        end
      end
      PM_DEEP: begin
        if (sleepWake) begin
          nxtState = PM_OSC_WAIT; strobe.ldOsc = 1'b1;
        end
      end
      PM_PDOWN: begin
        if (hardRst && tmrSeen) begin
          nxtState = PM_SUP_WAIT; strobe.ldSup = 1'b1;
        end
      end
      PM_SUP_WAIT: begin
        if (cntZero) begin
          nxtState = PM_OSC_WAIT; strobe.ldOsc = 1'b1;
        end
      end
      PM_OSC_WAIT, PM_RESYNC: begin
        if (cntZero) nxtState = PM_NORM_HI;
      end
      default: nxtState = PM_NORM_HI;
    endcase
    if (hardRst && !(curState inside {PM_PDOWN, PM_SUP_WAIT, PM_OSC_WAIT})) begin
      nxtState        = PM_NORM_HI;
      strobe.ldResync = 1'b0;
      strobe.ldOsc    = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) curState <= PM_NORM_HI;
    else       curState <= nxtState;
  end

  always_comb begin
    gclkEn   = curState inside {PM_NORM_HI, PM_NORM_LO, PM_DOZE_HI, PM_DOZE_LO, PM_RESYNC};
    pllEn    = gclkEn || (curState == PM_SLEEP) || (curState == PM_OSC_WAIT);
    coreEn   = (curState == PM_NORM_HI) || (curState == PM_NORM_LO);
    periphEn = gclkEn;
  end
endmodule

// File: rtl/lpm_sequencer.sv
module lpm_sequencer
  import lpm_pkg::*;
#(
  parameter int DIV_W = 3,
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             modeReq,
  input  logic [1:0]       modeSel,
  input  logic             timerExpSel,
  input  logic             useLow,
  input  logic [DIV_W-1:0] divHigh,
  input  logic [DIV_W-1:0] divLow,
  input  logic [CNT_W-1:0] oscSettle,
  input  logic [CNT_W-1:0] supplySettle,
  input  logic             hardRst,
  input  logic [5:0]       wakeSrc,
  input  logic [5:0]       wakeEn,
  output logic [3:0]       pmState,
  output logic [DIV_W:0]   divExp,
  output logic             gclkEn,
  output logic             pllEn,
  output logic             coreEn,
  output logic             periphEn
);
  pmStrobe_t            strobe;
  pmState_e             curState;
  logic [WAKE_BITS-1:0] wakeHit;
  logic                 cntZero;
  logic                 tmrSeen;

  assign pmState = curState;

  lpm_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .modeReq(modeReq), .modeSel(modeSel),
    .timerExpSel(timerExpSel), .useLow(useLow), .hardRst(hardRst),
    .wakeHit(wakeHit), .cntZero(cntZero), .tmrSeen(tmrSeen),
    .curState(curState), .strobe(strobe), .gclkEn(gclkEn), .pllEn(pllEn),
    .coreEn(coreEn), .periphEn(periphEn)
  );

  lpm_datapath #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .divHigh(divHigh), .divLow(divLow),
    .oscSettle(oscSettle), .supplySettle(supplySettle), .wakeSrc(wakeSrc),
    .wakeEn(wakeEn), .wakeHit(wakeHit), .divExp(divExp), .cntZero(cntZero),
    .tmrSeen(tmrSeen)
  );
endmodule

// File: rtl/lpm_sequencer_chk.sv
module lpm_sequencer_chk (
  input logic       clk,
  input logic       rstN,
  input logic       hardRst,
  input logic [5:0] wakeSrc,
  input logic [5:0] wakeEn,
  input logic [3:0] pmState,
  input logic       gclkEn,
  input logic       pllEn,
  input logic       coreEn
);
  logic [5:0] liveWake;
  assign liveWake = wakeSrc & wakeEn & 6'b111110;

  AST_HARD_RESET_NORM: assert property (@(posedge clk) disable iff (!rstN)
    (hardRst && !(pmState inside {4'd6, 4'd8, 4'd9})) |=> (pmState == 4'd0)); // R1

  AST_CORE_NEEDS_CLK: assert property (@(posedge clk) disable iff (!rstN)
    coreEn |-> (gclkEn && pllEn)); // R4

  AST_RESYNC_EXIT: assert property (@(posedge clk) disable iff (!rstN)
    (pmState == 4'd7 && $past(pmState) == 4'd7 && $past(pmState, 2) == 4'd7)
      |=> (pmState == 4'd0)); // R6

  AST_DEEP_TO_OSC: assert property (@(posedge clk) disable iff (!rstN)
    (pmState == 4'd5 && !hardRst && liveWake != 6'd0) |=> (pmState == 4'd8)); // R8

  AST_PDOWN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (pmState == 4'd6 && !hardRst) |=> (pmState == 4'd6)); // R9

  AST_MASKED_SLEEP: assert property (@(posedge clk) disable iff (!rstN)
    (pmState == 4'd4 && !hardRst && liveWake == 6'd0) |=> (pmState == 4'd4)); // R10
endmodule

bind lpm_sequencer lpm_sequencer_chk u_chk (.*);

// File: tb/lpm_sequencer_test.sv
`timescale 1ns/1ps
module lpm_sequencer_test;
  localparam int DIV_W = 3;
  localparam int CNT_W = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic modeReq = 1'b0;
  logic [1:0] modeSel = 2'b00;
  logic timerExpSel = 1'b0;
  logic useLow = 1'b0;
  logic [DIV_W-1:0] divHigh = 3'd3;
  logic [DIV_W-1:0] divLow = 3'd5;
  logic [CNT_W-1:0] oscSettle = 10'd5;
  logic [CNT_W-1:0] supplySettle = 10'd4;
  logic hardRst = 1'b0;
  logic [5:0] wakeSrc = 6'd0;
  logic [5:0] wakeEn = 6'h3F;
  logic [3:0] pmState;
  logic [DIV_W:0] divExp;
  logic gclkEn, pllEn, coreEn, periphEn;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  lpm_sequencer #(.DIV_W(DIV_W), .CNT_W(CNT_W)) uut (.*);

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic request(input logic [1:0] m, input logic low, input logic tes);
    modeSel = m; useLow = low; timerExpSel = tes; modeReq = 1'b1;
    step(1);
    modeReq = 1'b0;
  endtask

  task automatic wake(input logic [5:0] bits);
    wakeSrc = bits;
    step(1);
    wakeSrc = 6'd0;
  endtask

  task automatic pulseHard();
    hardRst = 1'b1;
    step(1);
    hardRst = 1'b0;
  endtask

  task automatic checkEn(input string req, input int g, input int p, input int c, input int ph);
    check({req, " gclkEn"}, gclkEn, g);
    check({req, " pllEn"}, pllEn, p);
    check({req, " coreEn"}, coreEn, c);
    check({req, " periphEn"}, periphEn, ph);
  endtask

  task automatic expectReturn(input string req);
    check({req, " enter return"}, pmState, 7);
    check({req, " core off in return"}, coreEn, 0);
    step(2);
    check({req, " still return"}, pmState, 7);
    step(1);
    check({req, " back to normal-high"}, pmState, 0);
    check({req, " core on"}, coreEn, 1);
  endtask

  task automatic testReset();
    check("R1 reset state", pmState, 0);
    checkEn("R1 reset", 1, 1, 1, 1);
    check("R3 reset divExp", divExp, 3);
  endtask

  task automatic testNormalLow();
    request(2'b00, 1'b0, 1'b0);
    check("R2 unchanged request", pmState, 0);
    request(2'b00, 1'b1, 1'b0);
    check("R2 normal-low", pmState, 1);
    check("R3 low divExp", divExp, 6);
    checkEn("R2 normal-low", 1, 1, 1, 1);
    request(2'b00, 1'b0, 1'b0);
    check("R3 return divExp", divExp, 3);
    expectReturn("R6 normal-low exit");
    request(2'b00, 1'b1, 1'b0);
    wake(6'b000001);
    expectReturn("R6 normal-low wake");
  endtask

  task automatic testDoze();
    request(2'b01, 1'b0, 1'b0);
    check("R2 doze-high", pmState, 2);
    checkEn("R4 doze", 1, 1, 0, 1);
    check("R3 doze-high divExp", divExp, 3);
    request(2'b10, 1'b0, 1'b0);
    check("R11 doze ignores code 10", pmState, 2);
    request(2'b00, 1'b1, 1'b0);
    expectReturn("R6 doze software exit");
    request(2'b01, 1'b1, 1'b0);
    check("R2 doze-low", pmState, 3);
    check("R3 doze-low divExp", divExp, 6);
    wakeEn = 6'b111110;
    wake(6'b000001);
    check("R10 masked internal in doze", pmState, 3);
    wakeEn = 6'h3F;
    wake(6'b000001);
    expectReturn("R6 doze wake");
  endtask

  task automatic testSleep();
    request(2'b10, 1'b0, 1'b0);
    check("R2 sleep", pmState, 4);
    checkEn("R5 sleep", 0, 1, 0, 0);
    request(2'b00, 1'b0, 1'b0);
    check("R11 sleep ignores request", pmState, 4);
    wake(6'b000001);
    check("R7 internal no wake", pmState, 4);
    wakeEn = 6'b111011;
    wake(6'b000100);
    check("R10 masked rtc", pmState, 4);
    check("R10 masked rtc gclk", gclkEn, 0);
    wakeEn = 6'h3F;
    wake(6'b001000);
    expectReturn("R7 sleep wake");
  endtask

  task automatic testDeep();
    request(2'b11, 1'b0, 1'b1);
    check("R2 deep-sleep", pmState, 5);
    checkEn("R5 deep", 0, 0, 0, 0);
    wake(6'b000010);
    check("R8 osc wait", pmState, 8);
    check("R8 osc pll", pllEn, 1);
    check("R8 osc gclk", gclkEn, 0);
    step(5);
    check("R8 osc wait end", pmState, 8);
    step(1);
    check("R8 normal-high", pmState, 0);
    check("R8 core on", coreEn, 1);
  endtask

  task automatic testPowerDown();
    request(2'b11, 1'b0, 1'b0);
    check("R2 power-down", pmState, 6);
    checkEn("R5 power-down", 0, 0, 0, 0);
    pulseHard();
    check("R9 hard reset before timer", pmState, 6);
    wake(6'b000010);
    check("R9 external wake ignored", pmState, 6);
    pulseHard();
    check("R9 hard reset after external", pmState, 6);
    wakeEn = 6'b101111;
    wake(6'b010000);
    pulseHard();
    check("R10 masked timer in power-down", pmState, 6);
    wakeEn = 6'h3F;
    wake(6'b100000);
    check("R9 timer wake holds", pmState, 6);
    pulseHard();
    check("R9 supply wait", pmState, 9);
    checkEn("R9 supply", 0, 0, 0, 0);
    step(4);
    check("R9 supply wait end", pmState, 9);
    step(1);
    check("R9 osc wait", pmState, 8);
    step(5);
    check("R9 osc wait end", pmState, 8);
    step(1);
    check("R9 normal-high", pmState, 0);
  endtask

  task automatic testHardReset();
    request(2'b01, 1'b1, 1'b0);
    pulseHard();
    check("R1 hard reset from doze", pmState, 0);
    checkEn("R1 after hard reset", 1, 1, 1, 1);
    request(2'b10, 1'b0, 1'b0);
    pulseHard();
    check("R1 hard reset from sleep", pmState, 0);
  endtask

  initial begin
    step(3);
    rstN = 1'b1;
    step(1);
    testReset();
    testNormalLow();
    testDoze();
    testSleep();
    testDeep();
    testPowerDown();
    testHardReset();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule